// File: doc/BRIEF.md
# Nested In-Service Interrupt Chain Tracker

This block keeps track of which interrupts a processor is currently servicing and the order in which they preempted each other. It stores one link per source. An interrupt that is in service points to the interrupt it interrupted. The running interrupt is the head of the resulting chain, and the value 1023 stands for "no interrupt", both as the running ID and as the end of the chain. Choosing which source wins is left to a neighbouring block. This tracker only reacts to the acknowledge that the processor issues for the winner and to the end-of-interrupt writes that follow.

An acknowledge pushes the acknowledged source on top of the chain. It emits a one-cycle pulse that clears that source's pending bit and loads the running priority from the source's priority input. An end-of-interrupt (EOI) that names the running interrupt pops it at once. An EOI that names an interrupt deeper in the chain starts a walk down the links, one link per clock with a busy flag raised, and splices the named entry out. Completion may therefore happen in any order. When a completed source is level-sensitive, enabled, and its input line is still high, the block emits a one-cycle pulse asking for its pending bit to be set again.

Top module: `nest_tracker`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 0x100, busy is low, and both pending pulse vectors are zero.
- R2: An acknowledge with ID n below NUM_SRC makes n the running interrupt on the next clock, loads the running priority with n's priority, and drives pend_clr_o with only bit n set for exactly one cycle. An acknowledge with ID NUM_SRC or above changes nothing.
- R3: An accepted EOI whose ID equals the running interrupt restores, on the next clock, the interrupt that it had preempted, along with that interrupt's priority. When the chain becomes empty the running ID is 1023 and the running priority is 0x100. No walk takes place.
- R4: An accepted EOI for an interrupt at depth j below the running one (j ≥ 1) keeps busy high for exactly j cycles and removes that entry from the chain. Later pops then skip it, and the running interrupt is unchanged.
- R5: An accepted EOI for a source below NUM_SRC that is not in the chain keeps busy high for as many cycles as the chain has entries. The chain and the running interrupt are left unchanged.
- R6: An EOI that arrives while the running ID is 1023 is ignored: no busy, no pending pulse, and no change.
- R7: On an accepted EOI of source n, pend_set_o has only bit n set in the following cycle, and only when trig_edge_i[n] is 0 (level-sensitive), src_en_i[n] is 1 and src_level_i[n] is 1. Otherwise pend_set_o stays zero.
- R8: An EOI is ignored, with no pending pulse and no chain change, in any of three cases: busy is high, ack_valid_i is high in the same cycle (the acknowledge is performed), or the EOI ID is NUM_SRC or above (including 1023).
- R9: An acknowledge taken while busy is high is performed at once, and the walk in progress still finishes in its original number of cycles with its splice applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | ID_W | ID being acknowledged |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_id_i | input | ID_W | ID being completed |
| src_level_i | input | NUM_SRC | Current line level of each source |
| src_en_i | input | NUM_SRC | Per-source enable |
| trig_edge_i | input | NUM_SRC | 1 = edge-triggered, 0 = level-sensitive |
| src_prio_i | input | NUM_SRC*PRIO_W | Packed per-source priority, source i in bits [i*PRIO_W +: PRIO_W] |
| running_id_o | output | ID_W | Running interrupt, 1023 when none |
| running_prio_o | output | PRIO_W+1 | Priority of the running interrupt, 0x100 when none |
| busy_o | output | 1 | A chain walk is in progress |
| pend_set_o | output | NUM_SRC | One-cycle request to set pending again |
| pend_clr_o | output | NUM_SRC | One-cycle request to clear pending on acknowledge |

## Verification
A corrupted link does not show up when it is written. It only appears later, as a wrong running ID (and running priority) after one of the following pops, or as a walk whose busy length differs from the depth of the target. For this reason, every out-of-order completion is followed by draining the whole chain one pop at a time, and each pop is compared against a model stack. Chains of one to six entries, with the EOI aimed at every position, exercise every splice depth. The busy length is counted on every EOI, so a walk that stops early or late is seen in the cycle in which it ends.

// File: rtl/nest_pkg.sv
package nest_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_st_e;
endpackage

// File: rtl/nest_reload.sv
// Per-source decision to mark a completed source pending again.
module nest_reload #(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 10
) (
    input  logic               fire_i,
    input  logic [ID_W-1:0]    id_i,
    input  logic [NUM_SRC-1:0] level_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] edge_i,
    output logic [NUM_SRC-1:0] set_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign set_o[i] = fire_i && (id_i == ID_W'(i)) && !edge_i[i] && en_i[i] && level_i[i];
    end
endmodule

// File: rtl/nest_prio_sel.sv
// Selects the priority that belongs to an ID; the idle value for "none".
module nest_prio_sel #(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 10,
    parameter int PRIO_W  = 8
) (
    input  logic [ID_W-1:0]           id_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat_i,
    output logic [PRIO_W:0]           prio_o
);
    localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

    always_comb begin
        prio_o = IDLE_PRIO;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (id_i == ID_W'(i)) begin
                prio_o = {1'b0, prio_flat_i[i*PRIO_W +: PRIO_W]};
            end
        end
    end
endmodule

// File: rtl/nest_tracker.sv
// Linked chain of in-service interrupts with out-of-order completion.
module nest_tracker
    import nest_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 10,
    parameter int PRIO_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ack_valid_i,
    input  logic [ID_W-1:0]           ack_id_i,
    input  logic                      eoi_valid_i,
    input  logic [ID_W-1:0]           eoi_id_i,
    input  logic [NUM_SRC-1:0]        src_level_i,
    input  logic [NUM_SRC-1:0]        src_en_i,
    input  logic [NUM_SRC-1:0]        trig_edge_i,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
    output logic [ID_W-1:0]           running_id_o,
    output logic [PRIO_W:0]           running_prio_o,
    output logic                      busy_o,
    output logic [NUM_SRC-1:0]        pend_set_o,
    output logic [NUM_SRC-1:0]        pend_clr_o
);
    localparam int              IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [ID_W-1:0] NONE_ID   = {ID_W{1'b1}};
    localparam logic [ID_W-1:0] NSRC_ID   = ID_W'(NUM_SRC);
    localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

    typedef struct packed {
        walk_st_e                     st;
        logic [ID_W-1:0]              run;
        logic [PRIO_W:0]              rprio;
        logic [ID_W-1:0]              cur;
        logic [ID_W-1:0]              tgt;
        logic [NUM_SRC-1:0][ID_W-1:0] link;
        logic [NUM_SRC-1:0]           pset;
        logic [NUM_SRC-1:0]           pclr;
    } trk_t;

    trk_t st_d, st_q;

    logic               ack_ok, eoi_ok;
    logic [ID_W-1:0]    nxt_link;
    logic [NUM_SRC-1:0] reload_vec;
    logic [PRIO_W:0]    new_prio;

    assign ack_ok = ack_valid_i && (ack_id_i < NSRC_ID);
    assign eoi_ok = eoi_valid_i && !ack_valid_i && (st_q.st == ST_IDLE)
                 && (st_q.run != NONE_ID) && (eoi_id_i < NSRC_ID);
    assign nxt_link = st_q.link[st_q.cur[IDX_W-1:0]];

    nest_reload #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_reload (
        .fire_i  (eoi_ok),
        .id_i    (eoi_id_i),
        .level_i (src_level_i),
        .en_i    (src_en_i),
        .edge_i  (trig_edge_i),
        .set_o   (reload_vec)
    );

    nest_prio_sel #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_prio (
        .id_i        (st_d.run),
        .prio_flat_i (src_prio_i),
        .prio_o      (new_prio)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pset  = reload_vec;
        st_d.pclr  = '0;

        // one link per clock while walking
        if (st_q.st == ST_WALK) begin
            if (nxt_link == NONE_ID) begin
                st_d.st = ST_IDLE;
            end else if (nxt_link == st_q.tgt) begin
                st_d.link[st_q.cur[IDX_W-1:0]] = st_q.link[st_q.tgt[IDX_W-1:0]];
                st_d.link[st_q.tgt[IDX_W-1:0]] = NONE_ID;
                st_d.st = ST_IDLE;
            end else begin
                st_d.cur = nxt_link;
            end
        end

        if (eoi_ok) begin
            if (eoi_id_i == st_q.run) begin
                st_d.run = st_q.link[st_q.run[IDX_W-1:0]];
                st_d.link[st_q.run[IDX_W-1:0]] = NONE_ID;
            end else begin
                st_d.st  = ST_WALK;
                st_d.cur = st_q.run;
                st_d.tgt = eoi_id_i;
            end
        end

        if (ack_ok) begin
            st_d.link[ack_id_i[IDX_W-1:0]] = st_q.run;
            st_d.run = ack_id_i;
            st_d.pclr[ack_id_i[IDX_W-1:0]] = 1'b1;
        end

        if (st_d.run != st_q.run) begin
            st_d.rprio = new_prio;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st    <= ST_IDLE;
            st_q.run   <= NONE_ID;
            st_q.rprio <= IDLE_PRIO;
            st_q.cur   <= NONE_ID;
            st_q.tgt   <= NONE_ID;
            st_q.link  <= {NUM_SRC{NONE_ID}};
            st_q.pset  <= '0;
            st_q.pclr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign running_id_o   = st_q.run;
    assign running_prio_o = st_q.rprio;
    assign busy_o         = (st_q.st == ST_WALK);
    assign pend_set_o     = st_q.pset;
    assign pend_clr_o     = st_q.pclr;
endmodule

// File: rtl/nest_tracker_chk.sv
module nest_tracker_chk #(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 10,
    parameter int PRIO_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack_valid_i,
    input logic [ID_W-1:0]    ack_id_i,
    input logic               eoi_valid_i,
    input logic [ID_W-1:0]    eoi_id_i,
    input logic [ID_W-1:0]    running_id_o,
    input logic [PRIO_W:0]    running_prio_o,
    input logic               busy_o,
    input logic [NUM_SRC-1:0] pend_set_o,
    input logic [NUM_SRC-1:0] pend_clr_o
);
    localparam logic [ID_W-1:0] NONE_ID   = {ID_W{1'b1}};
    localparam logic [ID_W-1:0] NSRC_ID   = ID_W'(NUM_SRC);
    localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

    // R3
    idle_prio_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_id_o == NONE_ID) == (running_prio_o == IDLE_PRIO));

    // R2
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_i && ack_id_i < NSRC_ID)
        |=> (running_id_o == $past(ack_id_i)) && ($countones(pend_clr_o) == 1));

    // R7
    pend_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_set_o) && $onehot0(pend_clr_o));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ack_valid_i) |=> $stable(running_id_o));

    // R6
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_id_o == NONE_ID && !ack_valid_i)
        |=> (running_id_o == NONE_ID) && !busy_o && (pend_set_o == '0));

    // R3
    pop_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && eoi_valid_i && !ack_valid_i && eoi_id_i == running_id_o
         && running_id_o != NONE_ID)
        |=> (running_id_o != $past(running_id_o)) && !busy_o);

    // R5
    busy_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (running_id_o != NONE_ID));
endmodule

bind nest_tracker nest_tracker_chk #(
    .NUM_SRC(NUM_SRC), .ID_W(ID_W), .PRIO_W(PRIO_W)
) u_nest_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ack_valid_i    (ack_valid_i),
    .ack_id_i       (ack_id_i),
    .eoi_valid_i    (eoi_valid_i),
    .eoi_id_i       (eoi_id_i),
    .running_id_o   (running_id_o),
    .running_prio_o (running_prio_o),
    .busy_o         (busy_o),
    .pend_set_o     (pend_set_o),
    .pend_clr_o     (pend_clr_o)
);

// File: tb/tb_nest_tracker.sv
`timescale 1ns/1ps
module tb_nest_tracker;
    localparam int N    = 8;
    localparam int IW   = 10;
    localparam int PW   = 8;
    localparam int NONE = 1023;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ack_valid_i = 1'b0;
    logic [IW-1:0]   ack_id_i = '0;
    logic            eoi_valid_i = 1'b0;
    logic [IW-1:0]   eoi_id_i = '0;
    logic [N-1:0]    src_level_i = '0;
    logic [N-1:0]    src_en_i = '0;
    logic [N-1:0]    trig_edge_i = '0;
    logic [N*PW-1:0] src_prio_i;
    logic [IW-1:0]   running_id_o;
    logic [PW:0]     running_prio_o;
    logic            busy_o;
    logic [N-1:0]    pend_set_o;
    logic [N-1:0]    pend_clr_o;

    int n_chk = 0;
    int n_fail = 0;
    int mstk[16];
    int mdep = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nest_tracker #(.NUM_SRC(N), .ID_W(IW), .PRIO_W(PW)) dut (
        .clk(clk), .rst_n(rst_n),
        .ack_valid_i(ack_valid_i), .ack_id_i(ack_id_i),
        .eoi_valid_i(eoi_valid_i), .eoi_id_i(eoi_id_i),
        .src_level_i(src_level_i), .src_en_i(src_en_i), .trig_edge_i(trig_edge_i),
        .src_prio_i(src_prio_i),
        .running_id_o(running_id_o), .running_prio_o(running_prio_o),
        .busy_o(busy_o), .pend_set_o(pend_set_o), .pend_clr_o(pend_clr_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int top_id();
        return (mdep == 0) ? NONE : mstk[mdep-1];
    endfunction

    function automatic int exp_prio(input int id);
        return (id == NONE) ? 256 : 16 * id + 5;
    endfunction

    function automatic int exp_pset(input int id);
        if (id >= N) return 0;
        return (!trig_edge_i[id] && src_en_i[id] && src_level_i[id]) ? (1 << id) : 0;
    endfunction

    task automatic check_run(input string req);
        chk(int'(running_id_o) == top_id(), req, int'(running_id_o), top_id());
        chk(int'(running_prio_o) == exp_prio(top_id()), req, int'(running_prio_o), exp_prio(top_id()));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ack_valid_i = 1'b0;
        eoi_valid_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mdep = 0;
        @(negedge clk);
    endtask

    task automatic do_ack(input int id);
        ack_valid_i = 1'b1;
        ack_id_i = IW'(id);
        @(negedge clk);
        ack_valid_i = 1'b0;
        if (id < N) begin
            mstk[mdep] = id;
            mdep++;
            chk(int'(pend_clr_o) == (1 << id), "R2", int'(pend_clr_o), 1 << id);
        end else begin
            chk(pend_clr_o == '0, "R2", int'(pend_clr_o), 0);
        end
        check_run("R2");
    endtask

    task automatic do_eoi(input int id, input string req);
        int pos;
        int exp_cyc;
        int cyc;
        int ps;
        bit acc;
        pos = -1;
        for (int k = 0; k < mdep; k++) if (mstk[k] == id) pos = k;
        acc = (mdep > 0) && (id < N);
        ps = acc ? exp_pset(id) : 0;
        if (!acc) exp_cyc = 0;
        else if (id == top_id()) exp_cyc = 0;
        else if (pos >= 0) exp_cyc = mdep - 1 - pos;
        else exp_cyc = mdep;
        eoi_valid_i = 1'b1;
        eoi_id_i = IW'(id);
        @(negedge clk);
        eoi_valid_i = 1'b0;
        chk(int'(pend_set_o) == ps, "R7", int'(pend_set_o), ps);
        cyc = 0;
        while (busy_o && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
        chk(cyc == exp_cyc, req, cyc, exp_cyc);
        if (acc && pos >= 0) begin
            for (int k = pos; k < mdep - 1; k++) mstk[k] = mstk[k+1];
            mdep--;
        end
        check_run(req);
    endtask

    task automatic drain();
        while (mdep > 0) do_eoi(top_id(), "R3");
        check_run("R3");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) src_prio_i[i*PW +: PW] = PW'(16 * i + 5);
        do_reset();
        // R1 reset state
        chk(int'(running_id_o) == NONE, "R1", int'(running_id_o), NONE);
        chk(int'(running_prio_o) == 256, "R1", int'(running_prio_o), 256);
        chk(busy_o == 1'b0, "R1", int'(busy_o), 0);
        chk(pend_set_o == '0 && pend_clr_o == '0, "R1", int'(pend_set_o | pend_clr_o), 0);

        // R6 EOI with nothing running
        src_level_i = '1; src_en_i = '1; trig_edge_i = '0;
        do_eoi(3, "R6");

        // R3 / R4 sweep: every chain depth and every completion position
        for (int d = 1; d <= 6; d++) begin
            for (int p = 0; p < d; p++) begin
                do_reset();
                src_level_i = N'(8'hA5 ^ (p * 37 + d));
                src_en_i    = N'(8'hFF ^ d);
                trig_edge_i = N'(8'h0F << p);
                for (int k = 0; k < d; k++) do_ack((k * 3 + d) % N);
                do_eoi(mstk[p], (p == d - 1) ? "R3" : "R4");
                drain();
            end
        end

        // R5 completion of an absent source
        do_reset();
        src_level_i = '1; src_en_i = '1; trig_edge_i = '0;
        for (int k = 0; k < 4; k++) do_ack(k);
        do_eoi(6, "R5");
        // R2 out-of-range acknowledge ignored
        do_ack(9);
        // R8 out-of-range EOI (1023 and NUM_SRC) ignored
        do_eoi(NONE, "R8");
        do_eoi(N, "R8");
        drain();

        // R8 acknowledge and EOI in the same cycle: ack wins
        do_reset();
        do_ack(0);
        do_ack(1);
        ack_valid_i = 1'b1; ack_id_i = IW'(5);
        eoi_valid_i = 1'b1; eoi_id_i = IW'(1);
        @(negedge clk);
        ack_valid_i = 1'b0; eoi_valid_i = 1'b0;
        mstk[mdep] = 5; mdep++;
        chk(pend_set_o == '0, "R8", int'(pend_set_o), 0);
        chk(busy_o == 1'b0, "R8", int'(busy_o), 0);
        check_run("R8");
        drain();

        // R9 ack during a walk; R8 EOI during a walk ignored
        do_reset();
        for (int k = 0; k < 4; k++) do_ack(k);
        eoi_valid_i = 1'b1; eoi_id_i = IW'(0);
        @(negedge clk);
        eoi_valid_i = 1'b0;
        chk(busy_o == 1'b1, "R9", int'(busy_o), 1);
        ack_valid_i = 1'b1; ack_id_i = IW'(6);
        @(negedge clk);
        ack_valid_i = 1'b0;
        chk(int'(running_id_o) == 6, "R9", int'(running_id_o), 6);
        chk(int'(running_prio_o) == exp_prio(6), "R9", int'(running_prio_o), exp_prio(6));
        chk(busy_o == 1'b1, "R9", int'(busy_o), 1);
        eoi_valid_i = 1'b1; eoi_id_i = IW'(6);
        @(negedge clk);
        eoi_valid_i = 1'b0;
        chk(busy_o == 1'b1, "R9", int'(busy_o), 1);
        chk(pend_set_o == '0, "R8", int'(pend_set_o), 0);
        chk(int'(running_id_o) == 6, "R8", int'(running_id_o), 6);
        @(negedge clk);
        chk(busy_o == 1'b0, "R9", int'(busy_o), 0);
        mstk[0] = 1; mstk[1] = 2; mstk[2] = 3; mstk[3] = 6; mdep = 4;
        check_run("R9");
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule